// File: doc/BRIEF.md
# Two-Phase DMA Transfer Controller

This block moves words from a single I/O device into a block of memory without help from the processor. Software first loads three settings while the block is idle: the I/O device address, the first memory address and the number of words to move. When the I/O device raises its transfer request, the block asks the processor for the shared bus. It touches none of the bus lines until the processor grants it.

Each word takes two bus cycles. In the read cycle the block puts the I/O address on the address bus and pulses the read strobe, and the device drives the data bus. The block captures that data in an internal holding register. In the following write cycle it puts the current memory address on the address bus, drives the held word onto the data bus and pulses the write strobe. After every write the memory address steps up by one and the remaining count steps down by one.

The block keeps the bus, going from read to write and back to read, until the count runs out or the device withdraws its request. It then drops its bus request and releases every bus line. A completion flag marks an exhausted count.

Top module: `dma_mover`

## Requirements
- R1: After reset, bus request is low, both address and data output enables are low, both strobes are high (inactive), and the completion flag is low.
- R2: With a non-zero count and the device request high, bus request is high in the cycle after the request is seen. While the grant stays low, no enable is raised and no strobe is pulsed.
- R3: In the cycle after a clock edge that samples the grant high (while requesting), the block runs a read cycle. The address bus carries the I/O address with its enable high, the read strobe is low, and the data enable is low.
- R4: The cycle right after a read is a write cycle. The address bus carries the current memory address, the data bus carries the word present on the data input during the read cycle, both enables are high and the write strobe is low.
- R5: Each strobe is low for exactly one clock per bus cycle, and the two strobes are never low in the same cycle.
- R6: Each write uses the memory address one higher than the previous write. The remaining count drops by one per write and keeps its value across a withdrawn request, so a later request resumes where the transfer stopped.
- R7: After the write that exhausts the count, the next cycle has bus request low, both enables low and both strobes high.
- R8: If the device request is low at the end of a write cycle, the bus is released in the next cycle as in R7. If it goes low while the block is still waiting for the grant, bus request drops in the next cycle and no bus cycle takes place.
- R9: The completion flag rises together with the release after the final write, and returns low when a new count is loaded.
- R10: Settings written while bus request is high are ignored. A count written during a transfer does not change the number of words moved.
- R11: With a count of zero, the device request is ignored: bus request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Settings write strobe, taken when idle |
| cfg_sel | input | 2 | Setting chosen: 0 I/O address, 1 memory address, 2 count |
| cfg_wdata | input | AW | Setting value (count uses the low CW bits) |
| dreq | input | 1 | Transfer request from the I/O device |
| breq | output | 1 | Bus request to the processor |
| back | input | 1 | Bus grant from the processor |
| addr_out | output | AW | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_in | input | DW | Data bus value as seen by the block |
| data_out | output | DW | Data bus value driven by the block |
| data_oe | output | 1 | Data bus drive enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | Count exhausted |

## Verification
The completion of a write and the withdrawal of the device request can fall in the same clock edge. Which one wins decides whether the block runs another read or lets go of the bus. The bench drops the request right after it has checked a read cycle, so the write that follows still happens. It then expects the bus to be released at once with the completion flag low. After that it raises the request again and checks that the next write lands two addresses past the start and that the count runs out on the following word. A count loaded while the block waits for the grant is a second such overlap; it is judged by the number of writes seen before the release.

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          breq,
  input  logic          back,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done
);

  localparam logic [1:0] SEL_IO  = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} state_t;

  state_t        st_q, st_d;
  logic [AW-1:0] io_q, mem_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q;
  logic          done_q;

  wire idle    = (st_q == S_IDLE);
  wire cfg_ok  = cfg_we && idle;
  wire last_wr = (cnt_q == CW'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (dreq && cnt_q != '0) st_d = S_REQ;
      S_REQ:  if (!dreq) st_d = S_IDLE;
              else if (back) st_d = S_RD;
      S_RD:   st_d = S_WR;
      S_WR:   if (last_wr || !dreq) st_d = S_IDLE;
              else if (back) st_d = S_RD;
              else st_d = S_REQ;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      io_q   <= '0;
      mem_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cfg_ok && cfg_sel == SEL_IO)  io_q <= cfg_wdata;
      if (cfg_ok && cfg_sel == SEL_MEM) mem_q <= cfg_wdata;
      if (cfg_ok && cfg_sel == SEL_CNT) begin
        cnt_q  <= cfg_wdata[CW-1:0];
        done_q <= 1'b0;
      end
      if (st_q == S_RD) hold_q <= data_in;
      if (st_q == S_WR) begin
        mem_q <= mem_q + AW'(1);
        cnt_q <= cnt_q - CW'(1);
        if (last_wr) done_q <= 1'b1;
      end
    end
  end

  assign breq     = !idle;
  assign addr_oe  = (st_q == S_RD) || (st_q == S_WR);
  assign data_oe  = (st_q == S_WR);
  assign rd_n     = !(st_q == S_RD);
  assign wr_n     = !(st_q == S_WR);
  assign addr_out = (st_q == S_WR) ? mem_q : io_q;
  assign data_out = hold_q;
  assign done     = done_q;

  // R5: strobes exclusive and single-cycle
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r5_rd_one: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> rd_n);
  a_r5_wr_one: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> wr_n);
  // R4: a write always follows a read
  a_r4_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> !wr_n && data_oe);
  // R2: no bus drive without request, first read only after grant
  a_r2_drive_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe || data_oe) |-> breq);
  a_r3_grant_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(rd_n) && $past(wr_n)) |-> $past(back));
  // R6: address advances per write
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> mem_q == $past(mem_q) + AW'(1));
  // R7: release with request
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(breq) |-> !addr_oe && !data_oe && rd_n && wr_n);
  // R9: done means nothing left
  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_q == '0);
  // R11: empty count never requests the bus
  a_r11_no_req_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cnt_q == '0) |=> !breq);

endmodule

// File: tb/sim_dma_mover.sv
module sim_dma_mover;
  localparam int AW = 16, DW = 8, CW = 8;

  logic          clk = 0, rst_n = 0;
  logic          cfg_we = 0;
  logic [1:0]    cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic          dreq = 0, back = 0;
  logic [DW-1:0] data_in = 0;
  logic          breq, addr_oe, data_oe, rd_n, wr_n, done;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] data_out;

  int errors = 0, checks = 0;

  dma_mover #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .breq(breq), .back(back),
    .addr_out(addr_out), .addr_oe(addr_oe), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rd_n(rd_n), .wr_n(wr_n),
    .done(done));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  function automatic logic [4:0] ctl;
    return {breq, addr_oe, data_oe, rd_n, wr_n};
  endfunction

  task automatic exp_idle(input string req);
    chk(ctl() == 5'b00011, req, 32'(ctl()), 32'h03);
  endtask

  task automatic exp_req(input string req);
    chk(ctl() == 5'b10011, req, 32'(ctl()), 32'h13);
  endtask

  task automatic exp_rd(input logic [AW-1:0] io);
    chk(ctl() == 5'b11001, "R3 R5 read cycle", 32'(ctl()), 32'h19);
    chk(addr_out == io, "R3 read address", 32'(addr_out), 32'(io));
  endtask

  task automatic exp_wr(input logic [AW-1:0] mem, input logic [DW-1:0] d);
    chk(ctl() == 5'b11110, "R4 R5 write cycle", 32'(ctl()), 32'h1E);
    chk(addr_out == mem, "R6 write address", 32'(addr_out), 32'(mem));
    chk(data_out == d, "R4 write data", 32'(data_out), 32'(d));
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] v);
    cfg_sel = sel; cfg_wdata = v; cfg_we = 1;
    step;
    cfg_we = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int n, input int l, input int k);
    return DW'((n * 16 + l * 4 + k) ^ 8'h5A);
  endfunction

  task automatic one_word(input logic [AW-1:0] io, input logic [AW-1:0] mem, input logic [DW-1:0] d);
    step; exp_rd(io);
    data_in = d;
    step; exp_wr(mem, d);
    data_in = ~d;
  endtask

  task automatic run_xfer(input int n, input int lat);
    logic [AW-1:0] io, mem;
    io  = AW'(16'hA000 + n);
    mem = AW'(16'h1000 * lat + 16'h100 * n);
    cfg(2'd0, io);
    cfg(2'd1, mem);
    cfg(2'd2, AW'(n));
    chk(done == 0, "R9 done cleared by count load", 32'(done), 0);
    dreq = 1;
    step; exp_req("R2 request raised");
    for (int i = 0; i < lat; i++) begin
      step; exp_req("R2 waiting for grant");
    end
    back = 1;
    for (int k = 0; k < n; k++) one_word(io, mem + AW'(k), pat(n, lat, k));
    step; exp_idle("R7 release after last write");
    chk(done == 1, "R9 done after last write", 32'(done), 1);
    dreq = 0; back = 0;
    step; exp_idle("R7 stays released");
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step; step;
    exp_idle("R1 reset outputs");
    chk(done == 0, "R1 reset done", 32'(done), 0);
    rst_n = 1;
    step; exp_idle("R1 after reset");

    // R11: empty count ignores request
    dreq = 1;
    for (int i = 0; i < 3; i++) begin
      step; exp_idle("R11 zero count ignored");
    end
    dreq = 0;

    // R2 R3 R4 R6 R7 R9 sweep over length and grant latency
    for (int n = 1; n <= 4; n++)
      for (int l = 0; l <= 3; l++) run_xfer(n, l);

    // R8: withdrawal while waiting for grant
    cfg(2'd0, 16'h00C0);
    cfg(2'd1, 16'h2000);
    cfg(2'd2, 16'd3);
    dreq = 1;
    step; exp_req("R8 request before withdrawal");
    dreq = 0;
    step; exp_idle("R8 withdrawn before grant");
    step; exp_idle("R8 no bus cycle");

    // R8 R6: withdrawal coinciding with a write, then resume
    dreq = 1;
    step; exp_req("R8 second request");
    back = 1;
    one_word(16'h00C0, 16'h2000, 8'h11);
    step; exp_rd(16'h00C0);
    data_in = 8'h22;
    dreq = 0;
    step; exp_wr(16'h2001, 8'h22);
    step; exp_idle("R8 release on withdrawal");
    chk(done == 0, "R8 count not exhausted", 32'(done), 0);
    back = 0;
    dreq = 1;
    step; exp_req("R6 resume request");
    back = 1;
    one_word(16'h00C0, 16'h2002, 8'h33);
    step; exp_idle("R6 resumed count exhausted");
    chk(done == 1, "R9 done after resume", 32'(done), 1);
    dreq = 0; back = 0;
    step;

    // R10: count load during transfer ignored
    cfg(2'd0, 16'h00D0);
    cfg(2'd1, 16'h3000);
    cfg(2'd2, 16'd2);
    dreq = 1;
    step; exp_req("R10 request");
    cfg(2'd2, 16'd9);
    exp_req("R10 still waiting");
    cfg(2'd1, 16'h7777);
    exp_req("R10 still waiting after address write");
    back = 1;
    one_word(16'h00D0, 16'h3000, 8'hA5);
    one_word(16'h00D0, 16'h3001, 8'h5A);
    step; exp_idle("R10 busy writes ignored");
    chk(done == 1, "R10 original count honoured", 32'(done), 1);
    dreq = 0; back = 0;
    cfg(2'd2, 16'd1);
    chk(done == 0, "R9 done cleared on reload", 32'(done), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule